// File: doc/BRIEF.md
# Distributor Global Control and Type Registers

This block holds the global control word of an interrupt distributor and produces its read-only type word. It sits on a simple single-beat register port: a request carries a valid flag, a write flag, a byte offset, write data and a secure attribute. Two offsets are decoded: the control word at 0x0 and the type word at 0x4. Any other offset, including any offset that is not word-aligned, reads as zero and ignores writes. No access ever returns a bus error.

Secure and non-secure accessors see the control word differently while the two security states are kept apart. Each accessor may also write a different set of bits. A security-disable bit merges the two states into one. Software can set it, but only a reset clears it. Setting it also drops the secure group-1 enable and the non-secure routing bit in the same write.

The group enables and the security-disable flag come out as registered levels for the rest of the distributor. Read data returns one cycle after the request.

Top module: `irq_dist_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0030 through a secure read and 0x0000_0010 through a non-secure read, and all four level outputs are low.
- R2: Bit 4 (secure routing enable) always reads 1. Bit 5 (non-secure routing enable) reads 1 until security is disabled. Writes never change either bit.
- R3: While security is enabled (bit 6 = 0), a non-secure read of the control word returns the secure view ANDed with 0x8000_0012. Bit 31 always reads 0.
- R4: While security is enabled, a secure write to offset 0x0 loads bit 0 (group-0 enable), bit 1 (non-secure group-1 enable), bit 2 (secure group-1 enable) and bit 6 (security disable). Every other written bit is ignored.
- R5: While security is enabled, a non-secure write to offset 0x0 changes only bit 1. Bit 6 stays 0 even if the write carries a 1 there.
- R6: A write that sets bit 6 clears bit 2 and bit 5 in that same update, even when the write data carries a 1 in bit 2.
- R7: Once bit 6 is 1, it stays 1 until reset. Any accessor may then write only bits 0 and 1, and both accessors read the full control word.
- R8: With default parameters (96 interrupts, LPI support on, revision 3), the type word reads 0x037A_0401 while security is enabled and 0x037A_0001 once it is disabled. The fields are: bits 25 and 24 set; bits 23:19 = 0xF; bit 18 set when the revision is at least 4; bit 17 = LPI support; bit 10 = NOT security disable; bits 4:0 = (interrupts − 32)/32 − 1.
- R9: Writes to offset 0x4 and to any reserved or unaligned offset change nothing. Reads of reserved or unaligned offsets return 0.
- R10: A read request is answered in the next cycle with rsp_valid high. Write requests and idle cycles leave rsp_valid low in the next cycle.
- R11: The outputs grp0_en, grp1ns_en, grp1s_en and sec_disabled equal bits 0, 1, 2 and 6 of the control word from the cycle after the write that sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Accessor is secure |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| grp0_en | output | 1 | Group-0 enable level |
| grp1ns_en | output | 1 | Non-secure group-1 enable level |
| grp1s_en | output | 1 | Secure group-1 enable level |
| sec_disabled | output | 1 | Security-disable level |

## Verification
Two effects can land in the same update: the write that sets the security-disable bit, and the loading of the secure group-1 enable from that same write. The bench provokes the overlap with one secure write of 0x47, which sets bit 6 and bits 2:0 together. Success means the control word then reads 0x53 through both accessors, with grp1s_en low and sec_disabled high. Later writes that try to set bit 2 or 5, or to clear bit 6, must leave those bits unchanged.

// File: rtl/irq_dist_ctrl_pkg.sv
package irq_dist_ctrl_pkg;

  // Bit positions inside the control word; the non-secure view and the
  // neighbouring distributor logic depend on these.
  localparam int CB_G0     = 0;
  localparam int CB_G1NS   = 1;
  localparam int CB_G1S    = 2;
  localparam int CB_RT_S   = 4;
  localparam int CB_RT_NS  = 5;
  localparam int CB_SECDIS = 6;
  localparam int CB_WPEND  = 31;

  localparam logic [31:0] NS_VIEW_MASK =
    (32'd1 << CB_WPEND) | (32'd1 << CB_RT_S) | (32'd1 << CB_G1NS);

  typedef struct packed {
    logic secdis;
    logic rt_ns;
    logic g1s;
    logic g1ns;
    logic g0;
  } ctl_state_t;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_TYPE = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_t;

  function automatic logic [31:0] ctl_word(input ctl_state_t s);
    logic [31:0] w;
    w = '0;
    w[CB_G0]     = s.g0;
    w[CB_G1NS]   = s.g1ns;
    w[CB_G1S]    = s.g1s;
    w[CB_RT_S]   = 1'b1;
    w[CB_RT_NS]  = s.rt_ns;
    w[CB_SECDIS] = s.secdis;
    w[CB_WPEND]  = 1'b0;
    return w;
  endfunction

endpackage

// File: rtl/irq_dist_ctrl_state.sv
module irq_dist_ctrl_state
  import irq_dist_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctl,
  input  logic       wr_secure,
  input  logic       wd_g0,
  input  logic       wd_g1ns,
  input  logic       wd_g1s,
  input  logic       wd_secdis,
  output ctl_state_t st
);

  ctl_state_t nxt;

  always_comb begin
    nxt = st;
    if (st.secdis) begin
      // single security state: only the two group enables move
      nxt.g0   = wd_g0;
      nxt.g1ns = wd_g1ns;
    end else if (wr_secure) begin
      nxt.g0     = wd_g0;
      nxt.g1ns   = wd_g1ns;
      nxt.g1s    = wd_g1s;
      nxt.secdis = wd_secdis;
      if (wd_secdis) begin
        nxt.g1s   = 1'b0;
        nxt.rt_ns = 1'b0;
      end
    end else begin
      nxt.g1ns = wd_g1ns;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st.g0     <= 1'b0;
      st.g1ns   <= 1'b0;
      st.g1s    <= 1'b0;
      st.rt_ns  <= 1'b1;
      st.secdis <= 1'b0;
    end else if (wr_ctl) begin
      st <= nxt;
    end
  end

  // R7: security disable is one-way
  a_r7_secdis_sticky: assert property (@(posedge clk) disable iff (rst)
    st.secdis |=> st.secdis);

  // R6: setting security disable drops dependent bits in the same update
  a_r6_secdis_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(st.secdis) |-> (!st.g1s && !st.rt_ns));

  // R2: non-secure routing bit stays set while security is enabled
  a_r2_routing_held: assert property (@(posedge clk) disable iff (rst)
    !st.secdis |-> st.rt_ns);

  // R5: non-secure write under security touches only the NS group-1 enable
  a_r5_ns_write_scope: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wr_secure && !st.secdis) |=>
      ($stable(st.g0) && $stable(st.g1s) && $stable(st.secdis)));

endmodule

// File: rtl/irq_dist_ctrl_type.sv
module irq_dist_ctrl_type #(
  parameter int NUM_IRQ  = 96,
  parameter bit LPI_EN   = 1'b1,
  parameter int REVISION = 3
) (
  input  logic        secdis,
  output logic [31:0] type_word
);

  localparam int          SPI_LINES = ((NUM_IRQ - 32) / 32) - 1;
  localparam logic [4:0]  LINES_FLD = SPI_LINES[4:0];
  localparam logic [4:0]  IDBITS    = 5'hF;

  logic dvis_bit;

  generate
    if (REVISION >= 4) begin : g_dvis
      assign dvis_bit = 1'b1;
    end else begin : g_nodvis
      assign dvis_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    type_word        = '0;
    type_word[25]    = 1'b1;
    type_word[24]    = 1'b1;
    type_word[23:19] = IDBITS;
    type_word[18]    = dvis_bit;
    type_word[17]    = LPI_EN;
    type_word[10]    = ~secdis;
    type_word[4:0]   = LINES_FLD;
  end

endmodule

// File: rtl/irq_dist_ctrl_rdport.sv
module irq_dist_ctrl_rdport
  import irq_dist_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  reg_sel_t    rd_sel,
  input  logic        rd_secure,
  input  ctl_state_t  st,
  input  logic [31:0] type_word,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);

  logic [31:0] ctl_view;
  logic [31:0] rd_mux;

  always_comb begin
    ctl_view = ctl_word(st);
    if (!st.secdis && !rd_secure)
      ctl_view = ctl_view & NS_VIEW_MASK;
    case (rd_sel)
      SEL_CTL:  rd_mux = ctl_view;
      SEL_TYPE: rd_mux = type_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
    end
  end

  // R10: one-cycle read response, none for writes or idle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);
  a_r10_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

endmodule

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_IRQ  = 96,
  parameter bit LPI_EN   = 1'b1,
  parameter int REVISION = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              grp0_en,
  output logic              grp1ns_en,
  output logic              grp1s_en,
  output logic              sec_disabled
);

  localparam int WORD_W   = ADDR_W - 2;
  localparam int CTL_WORD = 0;
  localparam int TYP_WORD = 1;

  reg_sel_t   sel;
  ctl_state_t st;
  logic [31:0] type_word;
  logic       wr_ctl;
  logic       rd_req;
  logic       unused_wdata;

  always_comb begin
    if (req_addr[1:0] != 2'b00)
      sel = SEL_NONE;
    else if (req_addr[ADDR_W-1:2] == WORD_W'(CTL_WORD))
      sel = SEL_CTL;
    else if (req_addr[ADDR_W-1:2] == WORD_W'(TYP_WORD))
      sel = SEL_TYPE;
    else
      sel = SEL_NONE;
  end

  assign wr_ctl       = req_valid && req_write && (sel == SEL_CTL);
  assign rd_req       = req_valid && !req_write;
  assign unused_wdata = ^{req_wdata[31:7], req_wdata[5:3]};

  irq_dist_ctrl_state u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .wr_secure (req_secure),
    .wd_g0     (req_wdata[CB_G0]),
    .wd_g1ns   (req_wdata[CB_G1NS]),
    .wd_g1s    (req_wdata[CB_G1S]),
    .wd_secdis (req_wdata[CB_SECDIS]),
    .st        (st)
  );

  irq_dist_ctrl_type #(
    .NUM_IRQ  (NUM_IRQ),
    .LPI_EN   (LPI_EN),
    .REVISION (REVISION)
  ) u_type (
    .secdis    (st.secdis),
    .type_word (type_word)
  );

  irq_dist_ctrl_rdport u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_sel    (sel),
    .rd_secure (req_secure),
    .st        (st),
    .type_word (type_word),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign grp0_en      = st.g0;
  assign grp1ns_en    = st.g1ns;
  assign grp1s_en     = st.g1s;
  assign sec_disabled = st.secdis;

  // R9: writes outside the control word leave the outputs alone
  a_r9_other_writes_inert: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && sel != SEL_CTL) |=>
      ($stable(grp0_en) && $stable(grp1ns_en) && $stable(grp1s_en)
       && $stable(sec_disabled)));

endmodule

// File: tb/sim_irq_dist_ctrl.sv
module sim_irq_dist_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_secure = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        grp0_en, grp1ns_en, grp1s_en, sec_disabled;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_dist_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .grp0_en(grp0_en),
    .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en), .sec_disabled(sec_disabled)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic sec, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    v = rsp_valid;
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, sec_disabled, grp1s_en, grp1ns_en, grp0_en};
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R1 outputs", outs(), 32'h0);
    rd(8'h00, 1'b1, d, v); chk("R1 secure ctl", d, 32'h30);
    chk("R10 read valid", {31'd0, v}, 32'h1);
    rd(8'h00, 1'b0, d, v); chk("R1 ns ctl", d, 32'h10);
  endtask

  task automatic t_secure_write();
    logic [31:0] d; logic v;
    wr(8'h00, 32'hFFFF_FFBF, 1'b1);
    chk("R10 no rsp on write", {31'd0, rsp_valid}, 32'h0);
    chk("R11 outputs", outs(), 32'h7);
    rd(8'h00, 1'b1, d, v); chk("R4 secure ctl", d, 32'h37);
    chk("R2 routing bits", d & 32'h30, 32'h30);
  endtask

  task automatic t_ns_view_write();
    logic [31:0] d; logic v;
    rd(8'h00, 1'b0, d, v); chk("R3 ns view", d, 32'h12);
    wr(8'h00, 32'h0, 1'b0);
    rd(8'h00, 1'b1, d, v); chk("R5 ns clear bit1", d, 32'h35);
    wr(8'h00, 32'hFFFF_FFFF, 1'b0);
    rd(8'h00, 1'b1, d, v); chk("R5 ns sets only bit1", d, 32'h37);
    chk("R5 secdis stays low", outs(), 32'h7);
    wr(8'h00, 32'h0, 1'b1);
    rd(8'h00, 1'b1, d, v); chk("R4 secure clear", d, 32'h30);
  endtask

  task automatic t_type_reserved();
    logic [31:0] d; logic v;
    rd(8'h04, 1'b1, d, v); chk("R8 type secure", d, 32'h037A_0401);
    rd(8'h04, 1'b0, d, v); chk("R8 type ns", d, 32'h037A_0401);
    wr(8'h04, 32'h0, 1'b1);
    rd(8'h04, 1'b1, d, v); chk("R9 type write ignored", d, 32'h037A_0401);
    rd(8'h08, 1'b1, d, v); chk("R9 reserved read", d, 32'h0);
    chk("R10 reserved read valid", {31'd0, v}, 32'h1);
    rd(8'h01, 1'b1, d, v); chk("R9 unaligned read", d, 32'h0);
    wr(8'h08, 32'h47, 1'b1);
    wr(8'h01, 32'h47, 1'b1);
    chk("R9 reserved write outputs", outs(), 32'h0);
    rd(8'h00, 1'b1, d, v); chk("R9 reserved write ctl", d, 32'h30);
  endtask

  task automatic t_secdis_set();
    logic [31:0] d; logic v;
    wr(8'h00, 32'h47, 1'b1);
    chk("R6 outputs", outs(), 32'hB);
    rd(8'h00, 1'b1, d, v); chk("R6 secure ctl", d, 32'h53);
    rd(8'h00, 1'b0, d, v); chk("R7 ns full view", d, 32'h53);
    rd(8'h04, 1'b1, d, v); chk("R8 type after disable", d, 32'h037A_0001);
  endtask

  task automatic t_secdis_sticky();
    logic [31:0] d; logic v;
    wr(8'h00, 32'h0, 1'b1);
    rd(8'h00, 1'b1, d, v); chk("R7 secdis sticky", d, 32'h50);
    wr(8'h00, 32'h3, 1'b0);
    rd(8'h00, 1'b0, d, v); chk("R7 ns writes enables", d, 32'h53);
    wr(8'h00, 32'h24, 1'b1);
    rd(8'h00, 1'b1, d, v); chk("R7 bits 2 and 5 locked", d, 32'h50);
    chk("R11 outputs after lock", outs(), 32'h8);
    @(negedge clk);
    chk("R10 idle no rsp", {31'd0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_secure_write();
    t_ns_view_write();
    t_type_reserved();
    t_secdis_set();
    t_secdis_sticky();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule